// File: doc/BRIEF.md
# Debug Trace Buffer Controller

This block watches the bus of a processor under debug and writes selected bus events into a 64-entry circular trace memory. A capture mode picks which events count. Change-of-flow mode records the source address of each taken branch. Loop mode does the same but drops an entry that repeats the source address written just before it. Detail mode records address and data of every data access. Program-counter mode records every instruction boundary. An active secure input stops all writing.

A session starts with a one-cycle `arm` pulse, which empties the memory. A `trig` pulse ends the session according to the alignment setting, so the trigger lands at the start, the middle or the end of the kept window. Once the session is complete, software reads the captured entries as a stream of 16-bit words, oldest entry first. Each entry gives two words: the address word first, then the data word. The data word is zero in every mode except detail mode.

The read side is a valid/ready stream. `rd_valid` is high only when the session is complete and unread words remain. A word is consumed on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value and `rd_valid` stays high. The bus monitor input is passive and has no back-pressure, because a traced processor cannot be stalled.

Top module: `trace_buf_ctrl`

## Requirements
- R1: After reset, and in the cycle after an `arm` pulse, `entry_count` is 0, `capture_done` is low and `rd_valid` is low. Arming also rewinds the read pointer.
- R2: In change-of-flow mode (`cfg_mode`=0), a cycle is written only when `mon_valid`, `mon_ibnd` and `mon_cof` are all high. The entry is {data word 0, address word `mon_addr`}.
- R3: Loop mode (`cfg_mode`=1) applies the R2 rule, but skips an event whose address equals the address of the entry written just before it in the same session.
- R4: Detail mode (`cfg_mode`=2) writes every valid cycle with `mon_kind`=0 (data access), storing {`mon_data`, `mon_addr`}. Kinds 1 (opcode fetch), 2 (free cycle) and 3 are never written.
- R5: Program-counter mode (`cfg_mode`=3) writes every valid cycle with `mon_ibnd` high, with data word 0.
- R6: While `secure` is high, nothing is written.
- R7: Begin alignment (`cfg_align`=0) writes nothing before the trigger. Capture starts with the trigger cycle and the session completes when the 64th entry is written.
- R8: End alignment (`cfg_align`=2) captures from the arm onward. The session completes at the trigger cycle, and that cycle's event is the last one kept.
- R9: Mid alignment (`cfg_align`=1) captures from the arm onward. The session completes when 32 entries have been written counting from the trigger cycle, so at most 32 entries from before the trigger survive.
- R10: Reading returns entries oldest first, address word then data word. The stream obeys the hold rule under back-pressure, and `rd_valid` drops once every word has been read.
- R11: The memory wraps and keeps the newest 64 entries. `entry_count` saturates at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Capture mode: 0 change-of-flow, 1 loop, 2 detail, 3 program counter |
| cfg_align | input | 2 | Trigger alignment: 0 begin, 1 mid, 2 end |
| arm | input | 1 | Start a new session and clear the memory |
| trig | input | 1 | Trigger pulse |
| secure | input | 1 | Suppresses all writes while high |
| mon_valid | input | 1 | A bus cycle is present |
| mon_addr | input | 16 | Bus address, or instruction address at a boundary |
| mon_data | input | 16 | Bus data |
| mon_kind | input | 2 | Cycle kind: 0 data, 1 opcode fetch, 2 free |
| mon_cof | input | 1 | Change-of-flow flag |
| mon_ibnd | input | 1 | Instruction-boundary strobe |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader accepts the word |
| rd_data | output | 16 | Read word |
| entry_count | output | 7 | Number of entries holding data |
| capture_done | output | 1 | Session complete |

## Verification
The embedded assertions check the following on every cycle:
- no write while `secure` is high;
- no back-to-back repeated address in loop mode;
- no write after the session completes;
- the count never exceeds the depth;
- arming empties the memory;
- the read stream holds its word under back-pressure.

Which events each mode picks, where each alignment places the trigger in the kept window, the oldest-first order after wrap, and the two-word layout can only be shown by the bench's scenarios. In those scenarios a reference model predicts each read word.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {MODE_COF, MODE_LOOP, MODE_DETAIL, MODE_PC} mode_e;
  typedef enum logic [1:0] {ALIGN_BEGIN, ALIGN_MID, ALIGN_END} align_e;
  typedef enum logic [1:0] {KIND_DATA, KIND_FETCH, KIND_FREE} kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST, ST_DONE} seq_e;
endpackage

// File: rtl/tbc_qual.sv
module tbc_qual
  import tbc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            cap_en,
  input  logic            secure,
  input  logic [1:0]      mode,
  input  logic            mon_valid,
  input  logic [AW-1:0]   mon_addr,
  input  logic [DW-1:0]   mon_data,
  input  logic [1:0]      mon_kind,
  input  logic            mon_cof,
  input  logic            mon_ibnd,
  output logic            wr_en,
  output logic [AW+DW-1:0] wr_word
);
  logic [AW-1:0] last_addr;
  logic          last_vld;
  logic          hit, dup;

  always_comb begin
    case (mode)
      MODE_COF, MODE_LOOP: hit = mon_valid & mon_ibnd & mon_cof;
      MODE_DETAIL:         hit = mon_valid & (mon_kind == KIND_DATA);
      default:             hit = mon_valid & mon_ibnd;
    endcase
    dup     = (mode == MODE_LOOP) && last_vld && (mon_addr == last_addr);
    wr_en   = cap_en & ~secure & hit & ~dup;
    wr_word = {(mode == MODE_DETAIL) ? mon_data : {DW{1'b0}}, mon_addr};
  end

  // loop filter remembers the address of the last written entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld  <= 1'b0;
      last_addr <= '0;
    end else if (clear) begin
      last_vld  <= 1'b0;
    end else if (wr_en) begin
      last_vld  <= 1'b1;
      last_addr <= mon_addr;
    end
  end

  a_r6_secure_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    secure |-> !wr_en);
  a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == MODE_LOOP && !clear) |=>
      !(wr_en && mode == MODE_LOOP && mon_addr == $past(mon_addr)));
endmodule

// File: rtl/tbc_seq.sv
module tbc_seq
  import tbc_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       trig,
  input  logic [1:0] align,
  input  logic       wr_en,
  output logic       cap_en,
  output logic       done
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  seq_e          st;
  logic [CW-1:0] post, post_nx, lim;

  always_comb begin
    lim     = (align == ALIGN_BEGIN) ? CW'(DEPTH) : CW'(HALF);
    cap_en  = (st == ST_PRE && (align != ALIGN_BEGIN || trig)) || st == ST_POST;
    post_nx = ((st == ST_POST) ? post : '0) + CW'(wr_en);
    done    = (st == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      post <= '0;
    end else if (arm) begin
      st   <= ST_PRE;
      post <= '0;
    end else begin
      case (st)
        ST_PRE: if (trig) begin
          if (align == ALIGN_END) st <= ST_DONE;
          else begin
            post <= post_nx;
            st   <= (post_nx == lim) ? ST_DONE : ST_POST;
          end
        end
        ST_POST: begin
          post <= post_nx;
          if (post_nx == lim) st <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  a_r1_arm_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done);
  a_r7_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
endmodule

// File: rtl/tbc_mem.sv
module tbc_mem #(
  parameter int DEPTH = 64,
  parameter int WW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [2*WW-1:0]            wr_word,
  input  logic                       done,
  input  logic                       rd_ready,
  output logic                       rd_valid,
  output logic [WW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [2*WW-1:0] mem [DEPTH];
  logic [PW-1:0]   wr_ptr, base, ent;
  logic [CW:0]     rd_idx;
  logic [2*WW-1:0] sel;

  always_comb begin
    base     = (count == CW'(DEPTH)) ? wr_ptr : '0;
    ent      = base + rd_idx[PW:1];
    sel      = mem[ent];
    rd_data  = rd_idx[0] ? sel[2*WW-1:WW] : sel[WW-1:0];
    rd_valid = done && (rd_idx < {count, 1'b0});
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clear) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
      rd_idx <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      count  <= '0;
      rd_idx <= '0;
    end else begin
      if (wr_en) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (count != CW'(DEPTH)) count <= count + 1'b1;
      end
      if (rd_valid && rd_ready) rd_idx <= rd_idx + 1'b1;
    end
  end

  a_r11_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r1_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !rd_valid));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !clear) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/trace_buf_ctrl.sv
module trace_buf_ctrl
  import tbc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_mode,
  input  logic [1:0]             cfg_align,
  input  logic                   arm,
  input  logic                   trig,
  input  logic                   secure,
  input  logic                   mon_valid,
  input  logic [AW-1:0]          mon_addr,
  input  logic [DW-1:0]          mon_data,
  input  logic [1:0]             mon_kind,
  input  logic                   mon_cof,
  input  logic                   mon_ibnd,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [DW-1:0]          rd_data,
  output logic [$clog2(DEPTH):0] entry_count,
  output logic                   capture_done
);
  logic             cap_en, wr_en;
  logic [AW+DW-1:0] wr_word;

  tbc_qual #(.AW(AW), .DW(DW)) u_qual (
    .clk(clk), .rst_n(rst_n), .clear(arm), .cap_en(cap_en), .secure(secure),
    .mode(cfg_mode), .mon_valid(mon_valid), .mon_addr(mon_addr),
    .mon_data(mon_data), .mon_kind(mon_kind), .mon_cof(mon_cof),
    .mon_ibnd(mon_ibnd), .wr_en(wr_en), .wr_word(wr_word)
  );

  tbc_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .align(cfg_align),
    .wr_en(wr_en), .cap_en(cap_en), .done(capture_done)
  );

  tbc_mem #(.DEPTH(DEPTH), .WW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .clear(arm), .wr_en(wr_en), .wr_word(wr_word),
    .done(capture_done), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .count(entry_count)
  );
endmodule

// File: tb/trace_buf_ctrl_tb.sv
module trace_buf_ctrl_tb;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0, cfg_align = 0, mon_kind = 0;
  logic arm = 0, trig = 0, secure = 0, mon_valid = 0, mon_cof = 0, mon_ibnd = 0;
  logic rd_ready = 0, rd_valid, capture_done;
  logic [15:0] mon_addr = 0, mon_data = 0, rd_data;
  logic [6:0] entry_count;

  always #5 clk = ~clk;

  trace_buf_ctrl u_dut (.*);

  int checks = 0, fails = 0;
  logic [31:0] expq[$];
  int mst = 0, mpost = 0;
  logic [15:0] mlast = 0;
  bit mlastv = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: applies one bus cycle and pushes the predicted entry to the scoreboard
  task automatic cyc(bit v, logic [15:0] a, logic [15:0] d, logic [1:0] k,
                     bit cof, bit ib, bit trg, bit sec);
    bit cap, hit, w;
    int lim;
    mon_valid = v; mon_addr = a; mon_data = d; mon_kind = k;
    mon_cof = cof; mon_ibnd = ib; trig = trg; secure = sec;
    cap = (mst == 1 && (cfg_align != 0 || trg)) || mst == 2;
    case (cfg_mode)
      0, 1: hit = v && ib && cof;
      2: hit = v && k == 0;
      default: hit = v && ib;
    endcase
    w = cap && !sec && hit && !(cfg_mode == 1 && mlastv && a == mlast);
    if (w) begin
      expq.push_back({(cfg_mode == 2) ? d : 16'h0, a});
      if (expq.size() > DEPTH) void'(expq.pop_front());
      mlast = a; mlastv = 1;
    end
    lim = (cfg_align == 0) ? DEPTH : DEPTH / 2;
    if (mst == 1 && trg) begin
      if (cfg_align == 2) mst = 3;
      else begin mpost = w ? 1 : 0; mst = (mpost == lim) ? 3 : 2; end
    end else if (mst == 2 && w) begin
      mpost++;
      if (mpost == lim) mst = 3;
    end
    @(posedge clk); @(negedge clk);
    mon_valid = 0; trig = 0; secure = 0;
  endtask

  task automatic do_arm(logic [1:0] m, logic [1:0] al);
    cfg_mode = m; cfg_align = al; arm = 1;
    expq.delete(); mst = 1; mpost = 0; mlastv = 0;
    @(posedge clk); @(negedge clk);
    arm = 0;
  endtask

  // monitor: pops expected entries and compares each read word
  task automatic drain(string req);
    int half = 0;
    bit held = 0;
    logic [15:0] hv = 0;
    chk(capture_done == (mst == 3), req, "done", capture_done, mst == 3);
    chk(entry_count == expq.size(), req, "entry_count", entry_count, expq.size());
    for (int n = 0; n < 1000 && expq.size() > 0; n++) begin
      if (held) chk(rd_data == hv && rd_valid, "R10", "hold under back-pressure", rd_data, hv);
      rd_ready = (n % 3 != 2);
      if (!rd_valid) begin
        chk(0, req, "rd_valid low with data pending", 0, 1);
        break;
      end
      held = !rd_ready; hv = rd_data;
      if (rd_ready) begin
        logic [15:0] e;
        e = half ? expq[0][31:16] : expq[0][15:0];
        chk(rd_data == e, req, "read word", rd_data, e);
        if (half) void'(expq.pop_front());
        half ^= 1;
      end
      @(negedge clk);
    end
    rd_ready = 0;
    chk(!rd_valid, "R10", "rd_valid after drain", rd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(entry_count == 0, "R1", "reset count", entry_count, 0);
    chk(!capture_done, "R1", "reset done", capture_done, 0);
    chk(!rd_valid, "R1", "reset rd_valid", rd_valid, 0);

    // R2 change-of-flow, end alignment
    do_arm(0, 2);
    for (int i = 0; i < 20; i++)
      cyc(1, 16'h1000 + 16'(i * 4), 16'(i), 2'(i % 3), i % 2 == 1, i % 4 != 3, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    drain("R2");

    // R3 loop filter
    do_arm(1, 2);
    for (int i = 0; i < 18; i++)
      cyc(1, 16'h2000 + 16'((i / 3) * 2), 16'h5555, 0, i % 5 != 4, 1, 0, 0);
    cyc(1, 16'h2000, 0, 0, 1, 1, 1, 0);
    drain("R3");

    // R4 detail
    do_arm(2, 2);
    for (int i = 0; i < 24; i++)
      cyc(i % 7 != 6, 16'h3000 + 16'(i), 16'hA000 + 16'(i), 2'(i % 4), 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    drain("R4");

    // R5 program counter with wrap (R11, R8 trigger entry last)
    do_arm(3, 2);
    for (int i = 0; i < 100; i++)
      cyc(1, 16'h4000 + 16'(i), 16'hFFFF, 1, 0, i % 5 != 0, 0, 0);
    cyc(1, 16'h4FFF, 0, 1, 0, 1, 1, 0);
    chk(entry_count == DEPTH, "R11", "saturated count", entry_count, DEPTH);
    drain("R8");

    // R6 secure lockout, then R1 re-arm with unread data
    do_arm(3, 2);
    for (int i = 0; i < 30; i++)
      cyc(1, 16'h5000 + 16'(i), 0, 1, 0, 1, 0, i >= 10 && i < 20);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    drain("R6");
    do_arm(3, 2);
    for (int i = 0; i < 5; i++) cyc(1, 16'h5800 + 16'(i), 0, 1, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    do_arm(3, 2);
    chk(entry_count == 0, "R1", "re-arm count", entry_count, 0);
    chk(!rd_valid, "R1", "re-arm rd_valid", rd_valid, 0);
    chk(!capture_done, "R1", "re-arm done", capture_done, 0);

    // R7 begin alignment
    do_arm(3, 0);
    for (int i = 0; i < 10; i++) cyc(1, 16'h6000 + 16'(i), 0, 1, 0, 1, 0, 0);
    chk(entry_count == 0, "R7", "no pre-trigger capture", entry_count, 0);
    cyc(1, 16'h6100, 0, 1, 0, 1, 1, 0);
    for (int i = 0; i < 70; i++) cyc(1, 16'h6200 + 16'(i), 0, 1, 0, 1, 0, 0);
    drain("R7");

    // R9 mid alignment
    do_arm(3, 1);
    for (int i = 0; i < 80; i++) cyc(1, 16'h7000 + 16'(i), 0, 1, 0, 1, 0, 0);
    cyc(1, 16'h7100, 0, 1, 0, 1, 1, 0);
    for (int i = 0; i < 40; i++) cyc(1, 16'h7200 + 16'(i), 0, 1, 0, i % 9 != 4, 0, 0);
    drain("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule